// File: doc/BRIEF.md
# Long-Descriptor Translation Table Walker

This block walks a multi-level translation table in the long-descriptor paging format. A walk is launched with an input address, the size of the input address space, a base register value, a stride (the grain exponent minus three: 9, 11 or 13), a start level and a flag picking the 64-bit or 32-bit regime. For each level the walker forms the address of an 8-byte descriptor and issues one read on a valid/ready request port. It then takes the single-beat response and classifies the returned word as a next-level table, a block, a page or an invalid entry.

Table descriptors carry the walk down one level. Their top five bits are ORed into an accumulated table-attribute value, and one of those bits moves every later read into the non-secure space for the rest of the walk. A block or page ends the walk with an output address and the level reached. An invalid entry or a bus error ends it with a fault and the level at which it happened. The index mask is sized by the input address space at the start level and by the grain at every later level. The next-table base is limited to the regime's physical width, and its low grain-size bits are cleared.

Top module: `desc_walk_top`

## Requirements
- R1: At the start level the table base is base_i[47:0] with its low W bits cleared, where W = in_size_i − stride×(4 − start level).
- R2: The first descriptor address is that base ORed with (in_addr_i >> stride×(4 − level)) masked to W ones, and every descriptor address has bits [2:0] equal to zero.
- R3: At every level after the start level the index is (in_addr_i >> stride×(4 − level)) masked to stride+3 ones.
- R4: The base for the next level is the table descriptor ANDed with 48 ones when wide_i=1 (40 ones when wide_i=0), with its low stride+3 bits cleared.
- R5: Descriptor bits [1:0] decode as follows: bit 0 clear is a fault. Below level 3, 2'b11 is a table and 2'b01 is a block. At level 3, 2'b11 is a page. Every other combination is a fault. On a fault out_addr_o is zero.
- R6: A table descriptor ORs its bits [63:59] into tbl_attr_o (bit i of tbl_attr_o collects descriptor bit 59+i), raises the level by one and issues the next read.
- R7: mem_req_ns_o is start_ns_i ORed with tbl_attr_o[4] (descriptor bit 63 of any table followed). Once high it stays high until the walk ends.
- R8: A block ends the walk at level 1 or 2 and a page at level 3. Encoding 2'b01 at level 0 is a fault. Each walk ends with a one-cycle done_o pulse, and level_o gives the final level.
- R9: On success out_addr_o holds the descriptor's bits [47:P] (limited to the regime width) joined with in_addr_i[P−1:0], where P = stride×(4 − level)+3.
- R10: mem_req_valid_o stays high with unchanged address and ns until mem_req_ready_i. Each level issues exactly one request, and the walker waits for its response before doing anything else.
- R11: A response with mem_rsp_err_i set ends the walk with fault_o high and level_o equal to the level of that read.
- R12: start_i is ignored while busy_o is high. The walk in progress completes with its own configuration.
- R13: After reset the walker is idle, with busy_o, mem_req_valid_o, done_o and fault_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a walk (taken only when idle) |
| in_addr_i | input | 64 | Input address to translate |
| in_size_i | input | 7 | Input address space size in bits |
| base_i | input | 64 | Base register value |
| stride_i | input | 4 | Stride (9, 11 or 13) |
| start_lvl_i | input | 2 | Start level |
| wide_i | input | 1 | 1 = 64-bit regime (48-bit table addresses), 0 = 32-bit regime (40-bit) |
| start_ns_i | input | 1 | Walk begins in the non-secure space |
| busy_o | output | 1 | Walk in progress |
| mem_req_valid_o | output | 1 | Descriptor read request valid |
| mem_req_ready_i | input | 1 | Request accepted |
| mem_req_addr_o | output | 48 | Descriptor address |
| mem_req_ns_o | output | 1 | Non-secure attribute of the read |
| mem_rsp_valid_i | input | 1 | Response beat valid |
| mem_rsp_data_i | input | 64 | Returned descriptor |
| mem_rsp_err_i | input | 1 | Response carries an error |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| fault_o | output | 1 | Walk ended in a fault |
| level_o | output | 2 | Current or final level |
| out_addr_o | output | 48 | Output address |
| tbl_attr_o | output | 5 | Accumulated table attributes |

## Verification
A wrong shift amount or mask width at any level appears on mem_req_addr_o in the very next request. The sweep therefore compares every descriptor address of every walk across all strides, start levels, start-index widths and both regimes. A wrong level counter or base register shows up one response later, as a wrong address, a wrong leaf classification or a wrong out_addr_o at the done_o pulse. A lost non-secure state shows on mem_req_ns_o in the read that follows the table that set it. Directed walks cover the invalid encodings at each level, a response error part-way down the walk, and a second start while busy.

// File: rtl/dwalk_pkg.sv
package dwalk_pkg;

    localparam int VA_W     = 64;
    localparam int DESC_W   = 64;
    localparam int SIZE_W   = 7;
    localparam int STRIDE_W = 4;
    localparam int LVL_W    = 2;
    localparam int ATTR_W   = 5;
    localparam int ATTR_LO  = 59;
    localparam int ATTR_NS  = 4;
    localparam int LEAF_LVL = 3;
    localparam logic [DESC_W-1:0] ALIGN_MASK = 64'h7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT
    } walk_state_e;

    typedef enum logic [1:0] {
        KIND_FAULT,
        KIND_TABLE,
        KIND_BLOCK,
        KIND_PAGE
    } desc_kind_e;

    typedef struct packed {
        logic [VA_W-1:0]     va;
        logic [SIZE_W-1:0]   isz;
        logic [STRIDE_W-1:0] stride;
        logic                wide;
    } walk_cfg_t;

    // n low ones, saturating at both ends
    function automatic logic [DESC_W-1:0] ones_mask(input int n);
        if (n <= 0)
            return '0;
        else if (n >= DESC_W)
            return '1;
        else
            return (64'd1 << n) - 64'd1;
    endfunction

    // bits of input address resolved below the given level
    function automatic int lvl_shift(input logic [STRIDE_W-1:0] stride,
                                     input logic [LVL_W-1:0] lvl);
        return int'(stride) * (4 - int'(lvl));
    endfunction

endpackage

// File: rtl/dwalk_addr_gen.sv
module dwalk_addr_gen
    import dwalk_pkg::*;
#(
    parameter int PA_W = 48
) (
    input  walk_cfg_t          cfg_i,
    input  logic [LVL_W-1:0]   level_i,
    input  logic               first_i,
    input  logic [PA_W-1:0]    base_i,
    output logic [PA_W-1:0]    addr_o
);
    localparam int PAD_W = DESC_W - PA_W;

    int                sh;
    int                start_w;
    logic [DESC_W-1:0] idx_mask;
    logic [DESC_W-1:0] base_ext;
    logic [DESC_W-1:0] full;

    always_comb begin
        sh       = lvl_shift(cfg_i.stride, level_i);
        start_w  = int'(cfg_i.isz) - sh;
        // start level: mask sized by input space; later: grain sized
        idx_mask = first_i ? ones_mask(start_w) : ones_mask(int'(cfg_i.stride) + 3);
        base_ext = {{PAD_W{1'b0}}, base_i};
        if (first_i)
            base_ext = base_ext & ~idx_mask;
        full   = (base_ext | ((cfg_i.va >> sh) & idx_mask)) & ~ALIGN_MASK;
        addr_o = full[PA_W-1:0];
    end

endmodule

// File: rtl/dwalk_classify.sv
module dwalk_classify
    import dwalk_pkg::*;
(
    input  logic [1:0]       tag_i,
    input  logic [LVL_W-1:0] level_i,
    output desc_kind_e       kind_o
);
    always_comb begin
        kind_o = KIND_FAULT;
        if (tag_i[0]) begin
            if (level_i == LVL_W'(LEAF_LVL)) begin
                if (tag_i[1])
                    kind_o = KIND_PAGE;
            end else if (tag_i[1]) begin
                kind_o = KIND_TABLE;
            end else if (level_i != '0) begin
                kind_o = KIND_BLOCK;
            end
        end
    end

endmodule

// File: rtl/dwalk_result.sv
module dwalk_result
    import dwalk_pkg::*;
#(
    parameter int PA_W        = 48,
    parameter int NARROW_PA_W = 40
) (
    input  logic [DESC_W-1:0]   desc_i,
    input  logic                wide_i,
    input  logic [STRIDE_W-1:0] stride_i,
    input  logic [LVL_W-1:0]    level_i,
    input  logic [VA_W-1:0]     va_i,
    output logic [PA_W-1:0]     next_base_o,
    output logic [PA_W-1:0]     out_addr_o
);
    localparam logic [DESC_W-1:0] WIDE_MASK   = ones_mask(PA_W);
    localparam logic [DESC_W-1:0] NARROW_MASK = ones_mask(NARROW_PA_W);

    logic [DESC_W-1:0] field;
    logic [DESC_W-1:0] grain_mask;
    logic [DESC_W-1:0] leaf_mask;
    logic [DESC_W-1:0] nb_full;
    logic [DESC_W-1:0] oa_full;

    always_comb begin
        field      = desc_i & (wide_i ? WIDE_MASK : NARROW_MASK);
        grain_mask = ones_mask(int'(stride_i) + 3);
        leaf_mask  = ones_mask(lvl_shift(stride_i, level_i) + 3);
        nb_full    = field & ~grain_mask;
        oa_full    = (field & ~leaf_mask) | (va_i & leaf_mask);
        next_base_o = nb_full[PA_W-1:0];
        out_addr_o  = oa_full[PA_W-1:0];
    end

endmodule

// File: rtl/desc_walk_top.sv
module desc_walk_top
    import dwalk_pkg::*;
#(
    parameter int PA_W        = 48,
    parameter int NARROW_PA_W = 40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [VA_W-1:0]     in_addr_i,
    input  logic [SIZE_W-1:0]   in_size_i,
    input  logic [DESC_W-1:0]   base_i,
    input  logic [STRIDE_W-1:0] stride_i,
    input  logic [LVL_W-1:0]    start_lvl_i,
    input  logic                wide_i,
    input  logic                start_ns_i,
    output logic                busy_o,
    output logic                mem_req_valid_o,
    input  logic                mem_req_ready_i,
    output logic [PA_W-1:0]     mem_req_addr_o,
    output logic                mem_req_ns_o,
    input  logic                mem_rsp_valid_i,
    input  logic [DESC_W-1:0]   mem_rsp_data_i,
    input  logic                mem_rsp_err_i,
    output logic                done_o,
    output logic                fault_o,
    output logic [LVL_W-1:0]    level_o,
    output logic [PA_W-1:0]     out_addr_o,
    output logic [ATTR_W-1:0]   tbl_attr_o
);
    walk_state_e        state_q;
    walk_cfg_t          cfg_q;
    logic [PA_W-1:0]    base_q;
    logic [LVL_W-1:0]   level_q;
    logic               first_q;
    logic [ATTR_W-1:0]  attr_q;
    logic               ns_start_q;
    logic               done_q;
    logic               fault_q;
    logic [PA_W-1:0]    out_q;

    logic [PA_W-1:0]    desc_addr;
    logic [PA_W-1:0]    next_base;
    logic [PA_W-1:0]    leaf_addr;
    desc_kind_e         kind;
    logic               rsp_take;

    dwalk_addr_gen #(.PA_W(PA_W)) addr_gen_i (
        .cfg_i   (cfg_q),
        .level_i (level_q),
        .first_i (first_q),
        .base_i  (base_q),
        .addr_o  (desc_addr)
    );

    dwalk_classify classify_i (
        .tag_i   (mem_rsp_data_i[1:0]),
        .level_i (level_q),
        .kind_o  (kind)
    );

    dwalk_result #(.PA_W(PA_W), .NARROW_PA_W(NARROW_PA_W)) result_i (
        .desc_i      (mem_rsp_data_i),
        .wide_i      (cfg_q.wide),
        .stride_i    (cfg_q.stride),
        .level_i     (level_q),
        .va_i        (cfg_q.va),
        .next_base_o (next_base),
        .out_addr_o  (leaf_addr)
    );

    assign rsp_take = (state_q == ST_WAIT) && mem_rsp_valid_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cfg_q      <= '0;
            base_q     <= '0;
            level_q    <= '0;
            first_q    <= 1'b0;
            attr_q     <= '0;
            ns_start_q <= 1'b0;
            done_q     <= 1'b0;
            fault_q    <= 1'b0;
            out_q      <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cfg_q.va     <= in_addr_i;
                        cfg_q.isz    <= in_size_i;
                        cfg_q.stride <= stride_i;
                        cfg_q.wide   <= wide_i;
                        base_q       <= base_i[PA_W-1:0];
                        level_q      <= start_lvl_i;
                        first_q      <= 1'b1;
                        attr_q       <= '0;
                        ns_start_q   <= start_ns_i;
                        fault_q      <= 1'b0;
                        out_q        <= '0;
                        state_q      <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready_i)
                        state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid_i) begin
                        if (mem_rsp_err_i) begin
                            fault_q <= 1'b1;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            unique case (kind)
                                KIND_TABLE: begin
                                    attr_q  <= attr_q | mem_rsp_data_i[ATTR_LO +: ATTR_W];
                                    base_q  <= next_base;
                                    level_q <= level_q + 1'b1;
                                    first_q <= 1'b0;
                                    state_q <= ST_REQ;
                                end
                                KIND_BLOCK, KIND_PAGE: begin
                                    out_q   <= leaf_addr;
                                    done_q  <= 1'b1;
                                    state_q <= ST_IDLE;
                                end
                                default: begin
                                    fault_q <= 1'b1;
                                    done_q  <= 1'b1;
                                    state_q <= ST_IDLE;
                                end
                            endcase
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o          = (state_q != ST_IDLE);
    assign mem_req_valid_o = (state_q == ST_REQ);
    assign mem_req_addr_o  = desc_addr;
    assign mem_req_ns_o    = ns_start_q | attr_q[ATTR_NS];
    assign done_o          = done_q;
    assign fault_o         = fault_q;
    assign level_o         = level_q;
    assign out_addr_o      = out_q;
    assign tbl_attr_o      = attr_q;

    // R10: request held stable until accepted
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid_o && !mem_req_ready_i) |=>
            (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_ns_o)));

    // R7: non-secure state never reverts inside a walk
    assert_ns_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && mem_req_ns_o) |=> (mem_req_ns_o || !busy_o));

    // R6: a followed table advances one level and issues the next read
    assert_lvl_step_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_take && !mem_rsp_err_i && kind == KIND_TABLE) |=>
            (level_q == $past(level_q) + 2'd1 && mem_req_valid_o));

    // R8: no successful walk ends at level 0; done is a single pulse
    assert_no_lvl0_leaf_R8: assert property (@(posedge clk) disable iff (rst)
        (done_o && !fault_o) |-> (level_o != '0));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R11: an error response ends the walk with a fault at the same level
    assert_err_fault_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_take && mem_rsp_err_i) |=>
            (done_o && fault_o && level_o == $past(level_q)));

endmodule

// File: tb/desc_walk_top_tb_top.sv
`timescale 1ns/1ps
module desc_walk_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [63:0] in_addr_i;
    logic [6:0]  in_size_i;
    logic [63:0] base_i;
    logic [3:0]  stride_i;
    logic [1:0]  start_lvl_i;
    logic        wide_i;
    logic        start_ns_i;
    logic        busy_o;
    logic        mem_req_valid_o;
    logic        mem_req_ready_i;
    logic [47:0] mem_req_addr_o;
    logic        mem_req_ns_o;
    logic        mem_rsp_valid_i;
    logic [63:0] mem_rsp_data_i;
    logic        mem_rsp_err_i;
    logic        done_o;
    logic        fault_o;
    logic [1:0]  level_o;
    logic [47:0] out_addr_o;
    logic [4:0]  tbl_attr_o;

    always #4 clk = ~clk;

    desc_walk_top dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .in_addr_i(in_addr_i),
        .in_size_i(in_size_i), .base_i(base_i), .stride_i(stride_i),
        .start_lvl_i(start_lvl_i), .wide_i(wide_i), .start_ns_i(start_ns_i),
        .busy_o(busy_o), .mem_req_valid_o(mem_req_valid_o),
        .mem_req_ready_i(mem_req_ready_i), .mem_req_addr_o(mem_req_addr_o),
        .mem_req_ns_o(mem_req_ns_o), .mem_rsp_valid_i(mem_rsp_valid_i),
        .mem_rsp_data_i(mem_rsp_data_i), .mem_rsp_err_i(mem_rsp_err_i),
        .done_o(done_o), .fault_o(fault_o), .level_o(level_o),
        .out_addr_o(out_addr_o), .tbl_attr_o(tbl_attr_o)
    );

    int total = 0;
    int bad   = 0;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    logic [63:0] desc_tab [4];
    logic        err_tab  [4];
    logic [47:0] exp_addr [4];
    logic        exp_ns   [4];
    int          exp_n;
    logic        exp_fault;
    logic [1:0]  exp_lvl;
    logic [47:0] exp_out;
    logic [4:0]  exp_attr;
    logic [47:0] got_addr [8];
    logic        got_ns   [8];
    int          got_n;
    logic        got_fault;
    logic [1:0]  got_lvl;
    logic [47:0] got_out;
    logic [4:0]  got_attr;

    task automatic step_rng();
        rng ^= rng << 13;
        rng ^= rng >> 7;
        rng ^= rng << 17;
    endtask

    function automatic logic [63:0] ones(input int n);
        if (n <= 0) return '0;
        if (n >= 64) return '1;
        return (64'd1 << n) - 64'd1;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected walk derived from the requirement formulas
    task automatic model(input logic [63:0] va, input int isz, input int s, input int sl,
                         input bit wide, input bit sns, input logic [63:0] base);
        logic [63:0] bse, im, d, rm, t;
        int lvl, k, pb;
        bit fin;
        lvl = sl;
        rm  = wide ? ones(48) : ones(40);
        im  = ones(isz - s * (4 - sl));
        bse = {16'h0, base[47:0]} & ~im;
        exp_attr = '0; exp_n = 0; exp_fault = 1'b0; exp_out = '0; fin = 0; k = 0;
        while (!fin && k < 4) begin
            t = (bse | ((va >> (s * (4 - lvl))) & im)) & ~64'd7;
            exp_addr[k] = t[47:0];
            exp_ns[k]   = sns | exp_attr[4];
            exp_n++;
            d = desc_tab[k];
            exp_lvl = 2'(lvl);
            if (err_tab[k]) begin
                exp_fault = 1'b1; fin = 1;
            end else if (!d[0]) begin
                exp_fault = 1'b1; fin = 1;
            end else if (lvl < 3 && d[1]) begin
                exp_attr = exp_attr | d[63:59];
                bse = d & rm & ~ones(s + 3);
                im  = ones(s + 3);
                lvl++;
                k++;
            end else if ((lvl < 3 && !d[1] && lvl > 0) || (lvl == 3 && d[1])) begin
                pb = s * (4 - lvl) + 3;
                t = (d & rm & ~ones(pb)) | (va & ones(pb));
                exp_out = t[47:0];
                fin = 1;
            end else begin
                exp_fault = 1'b1; fin = 1;
            end
        end
    endtask

    task automatic drive_start(input logic [63:0] va, input int isz, input int s, input int sl,
                               input bit wide, input bit sns, input logic [63:0] base);
        @(negedge clk);
        in_addr_i = va; in_size_i = 7'(isz); stride_i = 4'(s);
        start_lvl_i = 2'(sl); wide_i = wide; start_ns_i = sns; base_i = base;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic serve(input bit fast);
        bit fin;
        int guard;
        fin = 0; guard = 0; got_n = 0;
        while (!fin && guard < 300) begin
            @(negedge clk);
            guard++;
            step_rng();
            mem_req_ready_i = fast | rng[0];
            if (mem_req_valid_o && mem_req_ready_i) begin
                if (got_n < 8) begin
                    got_addr[got_n] = mem_req_addr_o;
                    got_ns[got_n]   = mem_req_ns_o;
                end
                @(negedge clk);
                mem_req_ready_i = 1'b0;
                repeat (int'(rng[2:1])) @(negedge clk);
                mem_rsp_valid_i = 1'b1;
                mem_rsp_data_i  = desc_tab[got_n < 4 ? got_n : 3];
                mem_rsp_err_i   = err_tab[got_n < 4 ? got_n : 3];
                @(negedge clk);
                mem_rsp_valid_i = 1'b0;
                mem_rsp_err_i   = 1'b0;
                got_n++;
                if (done_o) begin
                    fin = 1;
                    got_fault = fault_o; got_lvl = level_o;
                    got_out = out_addr_o; got_attr = tbl_attr_o;
                end
            end
        end
        mem_req_ready_i = 1'b0;
        if (!fin) chk("R10 walk completion", 64'd0, 64'd1);
    endtask

    task automatic compare();
        chk("R10 request count", 64'(got_n), 64'(exp_n));
        for (int k = 0; k < exp_n && k < got_n; k++) begin
            if (k == 0) chk("R1/R2 first descriptor address", 64'(got_addr[k]), 64'(exp_addr[k]));
            else        chk("R3/R4 later descriptor address", 64'(got_addr[k]), 64'(exp_addr[k]));
            chk("R7 request ns", 64'(got_ns[k]), 64'(exp_ns[k]));
        end
        chk("R5 fault", 64'(got_fault), 64'(exp_fault));
        chk("R8 final level", 64'(got_lvl), 64'(exp_lvl));
        chk("R9 output address", 64'(got_out), 64'(exp_out));
        chk("R6 table attributes", 64'(got_attr), 64'(exp_attr));
    endtask

    task automatic walk(input logic [63:0] va, input int isz, input int s, input int sl,
                        input bit wide, input bit sns, input logic [63:0] base, input bit fast);
        model(va, isz, s, sl, wide, sns, base);
        drive_start(va, isz, s, sl, wide, sns, base);
        serve(fast);
        compare();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] va, base;
        rst = 1'b1; start_i = 1'b0; in_addr_i = '0; in_size_i = '0; base_i = '0;
        stride_i = '0; start_lvl_i = '0; wide_i = 1'b0; start_ns_i = 1'b0;
        mem_req_ready_i = 1'b0; mem_rsp_valid_i = 1'b0; mem_rsp_data_i = '0; mem_rsp_err_i = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk("R13 busy after reset", 64'(busy_o), 64'd0);
        chk("R13 req valid after reset", 64'(mem_req_valid_o), 64'd0);
        chk("R13 done after reset", 64'(done_o), 64'd0);
        chk("R13 fault after reset", 64'(fault_o), 64'd0);

        // sweep: strides, start levels, start index widths, regimes, end levels
        for (int si = 0; si < 3; si++) begin
            for (int sl = 0; sl < 4; sl++) begin
                for (int ki = 0; ki < 3; ki++) begin
                    for (int w = 0; w < 2; w++) begin
                        for (int el = 1; el < 4; el++) begin
                            int s, kw, isz, endlvl;
                            s  = (si == 0) ? 9 : (si == 1) ? 11 : 13;
                            kw = (ki == 0) ? 1 : (ki == 1) ? (s + 3) / 2 : s + 3;
                            isz = s * (4 - sl) + kw;
                            endlvl = el;
                            if (isz <= 48 && endlvl >= sl) begin
                                for (int l = sl; l <= endlvl; l++) begin
                                    step_rng();
                                    desc_tab[l - sl] = {rng[63:2], (l == endlvl && l < 3) ? 2'b01 : 2'b11};
                                    err_tab[l - sl]  = 1'b0;
                                end
                                step_rng(); va = rng;
                                step_rng(); base = rng;
                                walk(va, isz, s, sl, w[0], va[5], base, va[9]);
                            end
                        end
                    end
                end
            end
        end

        // R5: invalid encodings
        for (int k = 0; k < 4; k++) err_tab[k] = 1'b0;
        step_rng(); va = rng; step_rng(); base = rng;
        desc_tab[0] = {rng[63:2], 2'b10};
        walk(va, 48, 9, 0, 1'b1, 1'b0, base, 1'b1);                 // R5 bit0 clear at level 0
        desc_tab[0] = {rng[63:2], 2'b01};
        walk(va, 48, 9, 0, 1'b1, 1'b0, base, 1'b0);                 // R8 block at level 0 faults
        chk("R8 level0 block faults", 64'(got_fault), 64'd1);
        desc_tab[0] = {rng[63:2], 2'b11}; desc_tab[1] = {rng[62:1], 2'b11};
        desc_tab[2] = {rng[61:0], 2'b11}; desc_tab[3] = {rng[63:2], 2'b01};
        walk(va, 48, 9, 0, 1'b0, 1'b0, base, 1'b1);                 // R5 01 at level 3 faults
        chk("R5 level3 01 faults", 64'(got_fault), 64'd1);
        chk("R5 level3 fault level", 64'(got_lvl), 64'd3);
        chk("R5 fault output zero", 64'(got_out), 64'd0);
        desc_tab[1] = {rng[63:2], 2'b00};
        walk(va, 39, 9, 1, 1'b1, 1'b0, base, 1'b0);                 // R5 invalid at level 2
        desc_tab[0] = 64'h8000_0000_0000_1003;                      // table with bit 63
        desc_tab[1] = 64'h0000_0000_0020_0003;
        desc_tab[2] = 64'h0000_0000_4000_0003;
        walk(va, 39, 9, 1, 1'b1, 1'b0, base, 1'b1);                 // R7 ns set after table
        chk("R7 ns after bit63 table", 64'(got_ns[1]), 64'd1);
        chk("R7 ns first read secure", 64'(got_ns[0]), 64'd0);

        // R11: error at level 2
        desc_tab[0] = {rng[63:2], 2'b11}; desc_tab[1] = {rng[60:0], 3'b011};
        err_tab[2] = 1'b1; desc_tab[2] = {rng[63:2], 2'b11};
        walk(va, 48, 9, 0, 1'b1, 1'b1, base, 1'b0);
        chk("R11 error fault", 64'(got_fault), 64'd1);
        chk("R11 error level", 64'(got_lvl), 64'd2);
        chk("R11 reads before error", 64'(got_n), 64'd3);
        err_tab[2] = 1'b0;

        // R12: start while busy is ignored
        desc_tab[0] = {rng[63:2], 2'b11}; desc_tab[1] = {rng[60:0], 3'b001};
        step_rng(); va = rng; step_rng(); base = rng;
        model(va, 30, 9, 2, 1'b1, 1'b0, base);
        drive_start(va, 30, 9, 2, 1'b1, 1'b0, base);
        @(negedge clk);
        in_addr_i = ~va; base_i = ~base; stride_i = 4'd13; start_lvl_i = 2'd1; start_ns_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        serve(1'b1);
        compare();
        chk("R12 walk unaffected by second start", 64'(got_out), 64'(exp_out));
        @(negedge clk);
        chk("R12 idle after walk", 64'(busy_o), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule